// File: doc/BRIEF.md
# SDRAM Power-Up Initialization and Refresh Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset until the memory is usable, and keeps it refreshed afterwards. Out of reset it holds clock enable and the data mask high and sends only no-operation commands for a long stabilisation wait. It then closes every bank with one precharge-all, runs a programmable number of auto-refresh commands, and loads the mode register with a word fixed at build time. Every wait between these steps is a parameter counted in clock cycles.

When the mode-register delay has passed, the block raises `ready_o` and drops the data mask, handing the data path to the rest of the controller. From then on it counts refresh intervals and keeps a debt of refreshes owed, up to a saturating limit. It asks for a slot with `ref_req_o` and flags `ref_urgent_o` when the debt is full. The controller answers with `ref_grant_i`. A grant sampled on a clock edge while `ref_req_o` is high makes the block send one auto refresh on the next cycle and then hold `ref_req_o` low for the refresh cycle time. A grant while the request is low is ignored. The request stays high, with no time limit, until a grant comes, so the controller may hold off refresh for as long as it likes; only the urgent flag warns that the debt is full. The controller must have closed all banks before it grants, because the refresh command carries no address.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, `cke_o` and `dqm_o` are 1, the command is NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111), and `ready_o` and `ref_req_o` are 0.
- R2: For the first PWR_WAIT cycles after reset release (cycles 0 to PWR_WAIT-1) the command is NOP. In cycle PWR_WAIT one precharge-all is sent: `{cs_n,ras_n,cas_n,we_n}` = 0010 with `addr_o[10]` = 1.
- R3: The first auto refresh (`{cs_n,ras_n,cas_n,we_n}` = 0001) comes exactly T_RP cycles after the precharge-all.
- R4: INIT_REFS auto refreshes are sent during initialization, each exactly T_RFC cycles after the one before.
- R5: Exactly T_RFC cycles after the last initialization refresh, one mode register set is sent: command 0000, `ba_o` = 0, `addr_o` = MODE_WORD (default 0x033: CAS latency 3 in bits 6:4, sequential type in bit 3, burst length 8 code in bits 2:0).
- R6: `ready_o` rises exactly T_MRD cycles after the mode register set and then stays high. `dqm_o` is 1 while `ready_o` is 0 and 0 once it is 1. `cke_o` is always 1.
- R7: On every cycle that is not one of the commands named in R2 to R5 or R10, the command is NOP with `addr_o` and `ba_o` at 0.
- R8: After `ready_o` rises, one refresh is owed every REF_INTERVAL cycles (the first owed refresh is visible REF_INTERVAL cycles after the first ready cycle). The debt saturates at DEBT_MAX. `ref_req_o` is high exactly when the block is idle in the ready state and the debt is nonzero.
- R9: `ref_urgent_o` is high exactly when the debt equals DEBT_MAX.
- R10: A grant sampled while `ref_req_o` is high produces an auto refresh on the next cycle and lowers the debt by one. `ref_req_o` stays low from that refresh cycle until T_RFC cycles after it.
- R11: A grant sampled while `ref_req_o` is low, including during initialization, sends no command and leaves the debt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_grant_i | input | 1 | Controller grants a refresh slot |
| cke_o | output | 1 | SDRAM clock enable |
| dqm_o | output | 1 | SDRAM data mask |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address lines |
| ready_o | output | 1 | Initialization complete |
| ref_req_o | output | 1 | Refresh owed and block idle |
| ref_urgent_o | output | 1 | Refresh debt at its limit |

## Verification
On every cycle the assertions check these properties: ready never falls once raised; no refresh is sent without a granted request; the request drops after a refresh is sent; the debt stays within its limit; and a full debt stays full until a refresh is sent. The exact command timeline (the NOP wait length, the precharge-all, the refresh spacing, the mode word on the address lines and the moment ready rises) is shown only by the bench's cycle-by-cycle comparison against its own schedule. The same holds for the interval at which debt builds up, its saturation under a long refusal, and the ignored grants with random timing.

// File: rtl/sdram_init_pkg.sv
`timescale 1ns/1ps
package sdram_init_pkg;

  // Command pin pattern {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PALL = 4'b0010,
    CMD_NOP  = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [3:0] {
    ST_PWAIT,   // long NOP wait after reset
    ST_PALL,    // precharge-all command cycle
    ST_TRP,     // precharge recovery
    ST_IREF,    // init refresh command cycle
    ST_ITRFC,   // init refresh recovery
    ST_MRS,     // mode register set command cycle
    ST_TMRD,    // mode register delay
    ST_RUN,     // ready, idle
    ST_RREF,    // granted refresh command cycle
    ST_RTRFC    // granted refresh recovery
  } seq_state_e;

endpackage

// File: rtl/sdram_wait_timer.sv
`timescale 1ns/1ps
module sdram_wait_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R4
  timer_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/sdram_ref_debt.sv
`timescale 1ns/1ps
module sdram_ref_debt #(
  parameter int INTERVAL = 1560,
  parameter int DEBT_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic issue_i,
  output logic owed_o,
  output logic full_o
);
  localparam int IW = $clog2(INTERVAL);
  localparam int DW = $clog2(DEBT_MAX + 1);

  logic [IW-1:0] icnt_q;
  logic [DW-1:0] debt_q;
  logic          tick;

  assign tick = en_i && (icnt_q == IW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   icnt_q <= '0;
    else if (en_i) icnt_q <= tick ? '0 : icnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) debt_q <= '0;
    else begin
      case ({tick, issue_i})
        2'b10: if (debt_q != DW'(DEBT_MAX)) debt_q <= debt_q + 1'b1;
        2'b01: debt_q <= debt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign owed_o = (debt_q != '0);
  assign full_o = (debt_q == DW'(DEBT_MAX));

  // R8
  debt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debt_q <= DW'(DEBT_MAX));

  // R9
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !issue_i) |=> full_o);

endmodule

// File: rtl/sdram_cmd_drive.sv
`timescale 1ns/1ps
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          BA_W      = 2,
  parameter logic [11:0] MODE_WORD = 12'h033
) (
  input  sdram_cmd_e        cmd_i,
  input  logic              ready_i,
  output logic              cke_o,
  output logic              dqm_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  assign cke_o = 1'b1;
  assign dqm_o = ~ready_i;
  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_i;
  assign ba_o  = '0;

  always_comb begin
    addr_o = '0;
    if (cmd_i == CMD_MRS)       addr_o = ADDR_W'(MODE_WORD);
    else if (cmd_i == CMD_PALL) addr_o[10] = 1'b1;
  end
endmodule

// File: rtl/sdram_init_seq.sv
`timescale 1ns/1ps
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int          ADDR_W       = 12,
  parameter int          BA_W         = 2,
  parameter int          PWR_WAIT     = 20000,
  parameter int          T_RP         = 2,
  parameter int          T_RFC        = 7,
  parameter int          T_MRD        = 2,
  parameter int          INIT_REFS    = 8,
  parameter int          REF_INTERVAL = 1560,
  parameter int          DEBT_MAX     = 8,
  parameter logic [11:0] MODE_WORD    = 12'h033
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_grant_i,
  output logic              cke_o,
  output logic              dqm_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o,
  output logic              ref_req_o,
  output logic              ref_urgent_o
);
  localparam int MAX_A = (PWR_WAIT > T_RFC) ? PWR_WAIT : T_RFC;
  localparam int MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_W + 1);
  localparam int RC_W  = $clog2(INIT_REFS + 1);

  seq_state_e       state_q;
  logic [RC_W-1:0]  refs_q;
  logic             t_zero, t_load;
  logic [CNT_W-1:0] t_val;
  logic             owed, full;
  sdram_cmd_e       cmd;

  // Each recovery state lasts (T - 1) cycles after its one-cycle command
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    case (state_q)
      ST_PALL:          begin t_load = 1'b1; t_val = CNT_W'(T_RP - 2);  end
      ST_IREF, ST_RREF: begin t_load = 1'b1; t_val = CNT_W'(T_RFC - 2); end
      ST_MRS:           begin t_load = 1'b1; t_val = CNT_W'(T_MRD - 2); end
      default: ;
    endcase
  end

  sdram_wait_timer #(.CNT_W(CNT_W), .RST_VAL(PWR_WAIT - 1)) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(t_load),
    .load_val_i(t_val), .zero_o(t_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWAIT;
      refs_q  <= '0;
    end else begin
      case (state_q)
        ST_PWAIT: if (t_zero) state_q <= ST_PALL;
        ST_PALL:  state_q <= ST_TRP;
        ST_TRP:   if (t_zero) state_q <= ST_IREF;
        ST_IREF:  begin
          refs_q  <= refs_q + 1'b1;
          state_q <= ST_ITRFC;
        end
        ST_ITRFC: if (t_zero)
          state_q <= (refs_q == RC_W'(INIT_REFS)) ? ST_MRS : ST_IREF;
        ST_MRS:   state_q <= ST_TMRD;
        ST_TMRD:  if (t_zero) state_q <= ST_RUN;
        ST_RUN:   if (ref_req_o && ref_grant_i) state_q <= ST_RREF;
        ST_RREF:  state_q <= ST_RTRFC;
        ST_RTRFC: if (t_zero) state_q <= ST_RUN;
        default:  state_q <= ST_PWAIT;
      endcase
    end
  end

  assign ready_o = (state_q == ST_RUN) || (state_q == ST_RREF) ||
                   (state_q == ST_RTRFC);

  sdram_ref_debt #(.INTERVAL(REF_INTERVAL), .DEBT_MAX(DEBT_MAX)) debt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ready_o),
    .issue_i(state_q == ST_RREF), .owed_o(owed), .full_o(full)
  );

  assign ref_req_o    = (state_q == ST_RUN) && owed;
  assign ref_urgent_o = full;

  always_comb begin
    case (state_q)
      ST_PALL:          cmd = CMD_PALL;
      ST_IREF, ST_RREF: cmd = CMD_REF;
      ST_MRS:           cmd = CMD_MRS;
      default:          cmd = CMD_NOP;
    endcase
  end

  sdram_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_WORD(MODE_WORD)) drv_i (
    .cmd_i(cmd), .ready_i(ready_o), .cke_o(cke_o), .dqm_o(dqm_o),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o)
  );

  // R6
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  // R11
  no_unasked_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !ref_req_o) |=>
      !(!cs_n_o && !ras_n_o && !cas_n_o && we_n_o));

  // R10
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !cs_n_o && !ras_n_o && !cas_n_o && we_n_o) |-> !ref_req_o);

endmodule

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;
  localparam int PW   = 40;
  localparam int TRP  = 3;
  localparam int TRFC = 5;
  localparam int TMRD = 2;
  localparam int NREF = 8;
  localparam int INTV = 60;
  localparam int DMAX = 8;
  localparam logic [11:0] MODE = 12'h033;

  localparam int F0  = PW + TRP;          // first init refresh
  localparam int MRS = F0 + NREF * TRFC;  // mode register set cycle
  localparam int RDY = MRS + TMRD;        // first ready cycle
  localparam int HOLD_END = RDY + (DMAX + 1) * INTV + 20;
  localparam int RAND_END = HOLD_END + 1500;
  localparam int K_END    = RAND_END + 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant = 1'b0;
  logic cke, dqm, cs_n, ras_n, cas_n, we_n, ready, req, urg;
  logic [1:0]  ba;
  logic [11:0] addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sdram_init_seq #(
    .ADDR_W(12), .BA_W(2), .PWR_WAIT(PW), .T_RP(TRP), .T_RFC(TRFC),
    .T_MRD(TMRD), .INIT_REFS(NREF), .REF_INTERVAL(INTV),
    .DEBT_MAX(DMAX), .MODE_WORD(MODE)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_grant_i(grant),
    .cke_o(cke), .dqm_o(dqm), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr),
    .ready_o(ready), .ref_req_o(req), .ref_urgent_o(urg)
  );

  task automatic chk(input string tag, input int k, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d act=%0h exp=%0h", tag, k, act, exp);
    end
  endtask

  // Expected command pattern during initialization
  function automatic logic [3:0] init_cmd(input int k);
    if (k == PW) return 4'b0010;
    if (k >= F0 && k < MRS && ((k - F0) % TRFC) == 0) return 4'b0001;
    if (k == MRS) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic string init_tag(input int k);
    if (k < PW || k == PW) return "R2";
    if (k == F0) return "R3";
    if (k < MRS) return "R4";
    if (k == MRS) return "R5";
    return "R7";
  endfunction

  function automatic logic [11:0] exp_addr(input logic [3:0] c);
    if (c == 4'b0000) return MODE;
    if (c == 4'b0010) return 12'h400;
    return 12'h000;
  endfunction

  initial begin
    int ref_at;
    int run_free;
    int debt;
    bit ign_prev;
    void'($urandom(32'hC0FFEE));
    ref_at = -100; run_free = 0; debt = 0; ign_prev = 1'b0;

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R1 cke", 0, cke, 1); chk("R1 dqm", 0, dqm, 1);
      chk("R1 cmd", 0, {cs_n, ras_n, cas_n, we_n}, 4'b0111);
      chk("R1 ready", 0, ready, 0); chk("R1 req", 0, req, 0);
    end
    rst_n = 1'b1;

    for (int k = 0; k <= K_END; k++) begin
      logic [3:0] ecmd;
      string tag;
      bit tick, dec, idle, g;
      if (k > 0) @(negedge clk);

      // debt model (R8, R9, R10)
      tick = (k > RDY) && (((k - RDY) % INTV) == 0);
      dec  = (ref_at == k - 1);
      if (dec) debt--;
      if (tick && debt < DMAX) debt++;

      if (k < RDY) begin
        ecmd = init_cmd(k);
        tag  = init_tag(k);
      end else if (k == ref_at) begin
        ecmd = 4'b0001; tag = "R10";
      end else begin
        ecmd = 4'b0111; tag = ign_prev ? "R11" : "R7";
      end
      idle = (k >= RDY) && (k >= run_free) && (k != ref_at);

      chk(tag, k, {cs_n, ras_n, cas_n, we_n}, ecmd);
      chk(tag, k, addr, exp_addr(ecmd));
      chk("R7 ba", k, ba, 0);
      chk("R6 cke", k, cke, 1);
      chk("R6 ready", k, ready, k >= RDY);
      chk("R6 dqm", k, dqm, k < RDY);
      chk("R8 req", k, req, idle && debt > 0);
      chk("R9 urgent", k, urg, debt == DMAX);

      // next grant: random in init (R11), refused while debt builds, then mixed
      if (k < RDY)            g = ($urandom % 2) == 1;
      else if (k < HOLD_END)  g = 1'b0;
      else if (k < RAND_END)  g = ($urandom % 3) == 0;
      else                    g = 1'b1;
      ign_prev = g && !(idle && debt > 0);
      if (g && idle && debt > 0) begin
        ref_at   = k + 1;
        run_free = k + 1 + TRFC;
      end
      grant = g;
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #((K_END + 2000) * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule